// File: doc/BRIEF.md
# Sinusoidal PWM Modulator with Triangular Carrier

This block turns a digital sine reference into a two-level switching command for a single-phase bridge. A fractional phase accumulator walks a sine table with one entry per degree of the output cycle. Once per carrier period, at the top of a symmetric up/down carrier, the addressed entry is scaled by the modulation index and by a soft-start envelope, then turned into a compare threshold. The command is high (positive rail) while the carrier sits below that threshold and low (negative rail) otherwise. It never has a third state.

On enable the envelope climbs linearly from zero to unity over a parameterised ramp time, 500 ms by default. The output frequency is chosen by one select pin, 50 Hz or 60 Hz by default, against a 20 kHz carrier. Two strobes let a controller align to the waveform. One marks each carrier top, where the reference is refreshed. The other marks the start of each fundamental cycle. Dead-time insertion, gate drive and output filtering belong to the stages that follow.

Top module: `spwm_modulator`

## Requirements
- R1: While enabled and out of reset, `pwm_o` is always a defined rail command: 1 selects the positive rail, 0 the negative rail, with no third state.
- R2: The carrier counts up from 0 to HALF = CLK_HZ/(2*CARRIER_HZ), then down to 1, then restarts at 0, for a period of 2*HALF clocks. The first count after enable is 0. `peak_o` is high for exactly one clock, in the cycle after the counter holds HALF, so successive pulses are 2*HALF clocks apart.
- R3: The compare threshold changes only at a carrier top. The new threshold takes effect in the same cycle that `peak_o` is high. `pwm_o` is the registered result of (carrier < threshold), one clock behind the counter, so it has at most one rising edge per carrier period.
- R4: Table entry k (k = 0..359, in degrees) equals trunc(A*4*m*(180-m)/(40500-m*(180-m))), where m = k mod 180 and A = 2^(SAMPLE_W-1)-1. Entries for k >= 180 are negated. At a carrier top the entry is read from the integer part of the phase before the phase advances.
- R5: The phase holds 16 fraction bits and wraps at 360*2^16. At each carrier top it advances by round(360*2^16*F/CARRIER_HZ). F is FOUT0_HZ when `freq_sel_i` = 0 and FOUT1_HZ when `freq_sel_i` = 1.
- R6: `zc_o` is high for one clock, in the same cycle as `peak_o`, when a phase advance wraps past 359 degrees back to 0.
- R7: Let depth = (mod_index*envelope)>>15, where `mod_index_i` is unsigned Q1.15. Let s = (entry*depth)>>>15, with an arithmetic shift. The threshold is (clamp(s+2048, 0, 4096)*HALF)>>12, so over-modulation saturates at 0 or HALF.
- R8: The envelope starts at 0 on enable. At each carrier top, after its value has been used, it increases by ceil(32768/P) and saturates at 32768, where P = CARRIER_HZ*RAMP_MS/1000.
- R9: While `en_i` is low, `pwm_o`, `peak_o` and `zc_o` are 0 from the next cycle. Carrier, phase and envelope return to zero, and the threshold returns to HALF/2, so the ramp restarts on the next enable.
- R10: Synchronous active-high `rst_i` puts the block in the same idle state as R9, with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low holds the block idle |
| freq_sel_i | input | 1 | Output frequency select: 0 for FOUT0_HZ, 1 for FOUT1_HZ |
| mod_index_i | input | MI_W | Modulation index, unsigned Q1.15 |
| pwm_o | output | 1 | Rail command: 1 positive, 0 negative |
| peak_o | output | 1 | One-clock strobe at each carrier top |
| zc_o | output | 1 | One-clock strobe at each fundamental cycle start |

## Verification
Three events can land in the same clock: the carrier top that refreshes the threshold, the phase wrap that raises `zc_o`, and the envelope step. The bench runs the block through complete fundamental cycles at both frequencies, so the wrap must fall on a carrier top. A behavioural model that advances phase and envelope in integer arithmetic is compared with all three outputs on every clock. A disable is also dropped in the middle of a carrier period, and the model requires the idle state and a fresh ramp afterwards. Running with an over-range modulation index drives the threshold into its clamps at the same tops where the table address moves.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

   typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} ramp_dir_e;

   // Integer half-wave sine shape; index in degrees, result scaled to amp.
   function automatic int sine_entry(input int deg, input int amp);
      int m;
      int p;
      int v;
      m = deg % 180;
      p = m * (180 - m);
      v = (amp * 4 * p) / (40500 - p);
      return (deg >= 180) ? -v : v;
   endfunction

endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
   parameter int HALF = 2500,
   parameter int CW   = $clog2(HALF + 1)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          en_i,
   output logic [CW-1:0] cnt_o,
   output logic          top_o
);
   import spwm_pkg::*;

   localparam logic [CW-1:0] TOP = CW'(HALF);

   ramp_dir_e dir_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i) begin
         cnt_o <= '0;
         dir_q <= DIR_UP;
      end else if (dir_q == DIR_UP) begin
         if (cnt_o == TOP - 1'b1) begin
            cnt_o <= TOP;
            dir_q <= DIR_DOWN;
         end else begin
            cnt_o <= cnt_o + 1'b1;
         end
      end else begin
         if (cnt_o == CW'(1)) begin
            cnt_o <= '0;
            dir_q <= DIR_UP;
         end else begin
            cnt_o <= cnt_o - 1'b1;
         end
      end
   end

   assign top_o = (cnt_o == TOP);

endmodule

// File: rtl/spwm_phase.sv
module spwm_phase #(
   parameter int FRAC     = 16,
   parameter int SAMPLE_W = 12,
   parameter int STEP0    = 58982,
   parameter int STEP1    = 70779,
   parameter int QUARTER  = 1
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       en_i,
   input  logic                       adv_i,
   input  logic                       sel_i,
   output logic signed [SAMPLE_W-1:0] sample_o,
   output logic                       wrap_o
);
   import spwm_pkg::*;

   localparam int MOD   = 360 * (2 ** FRAC);
   localparam int ACC_W = $clog2(MOD);
   localparam int IDX_W = ACC_W - FRAC;
   localparam int AMP   = 2 ** (SAMPLE_W - 1) - 1;
   localparam logic [ACC_W:0] MODV = (ACC_W + 1)'(MOD);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   step;
   logic [ACC_W:0]   sum;
   logic             past_end;
   logic [IDX_W-1:0] idx;

   assign step     = sel_i ? (ACC_W + 1)'(STEP1) : (ACC_W + 1)'(STEP0);
   assign sum      = {1'b0, acc_q} + step;
   assign past_end = (sum >= MODV);
   assign wrap_o   = en_i && adv_i && past_end;
   assign idx      = acc_q[ACC_W-1:FRAC];

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i) begin
         acc_q <= '0;
      end else if (adv_i) begin
         acc_q <= past_end ? ACC_W'(sum - MODV) : sum[ACC_W-1:0];
      end
   end

   if (QUARTER != 0) begin : g_quarter
      localparam int QN  = 91;
      localparam int QIW = $clog2(QN);
      logic signed [SAMPLE_W-1:0] rom [0:QN-1];
      logic [IDX_W-1:0] in_half;
      logic [IDX_W-1:0] folded;
      logic             neg;
      for (genvar g = 0; g < QN; g++) begin : g_rom
         assign rom[g] = SAMPLE_W'(sine_entry(g, AMP));
      end
      assign neg      = (idx >= IDX_W'(180));
      assign in_half  = neg ? idx - IDX_W'(180) : idx;
      assign folded   = (in_half > IDX_W'(90)) ? IDX_W'(180) - in_half : in_half;
      assign sample_o = neg ? -rom[folded[QIW-1:0]] : rom[folded[QIW-1:0]];
   end else begin : g_full
      localparam int FN  = 360;
      localparam int FIW = $clog2(FN);
      logic signed [SAMPLE_W-1:0] rom [0:FN-1];
      for (genvar g = 0; g < FN; g++) begin : g_rom
         assign rom[g] = SAMPLE_W'(sine_entry(g, AMP));
      end
      assign sample_o = rom[idx[FIW-1:0]];
   end

endmodule

// File: rtl/spwm_envelope.sv
module spwm_envelope #(
   parameter int W    = 16,
   parameter int STEP = 4
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         en_i,
   input  logic         adv_i,
   output logic [W-1:0] env_o
);
   localparam logic [W:0]   FULLX = (W + 1)'(2 ** (W - 1));
   localparam logic [W-1:0] FULL  = W'(2 ** (W - 1));

   logic [W:0] sum;
   assign sum = {1'b0, env_o} + (W + 1)'(STEP);

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i) begin
         env_o <= '0;
      end else if (adv_i) begin
         env_o <= (sum >= FULLX) ? FULL : sum[W-1:0];
      end
   end

endmodule

// File: rtl/spwm_modulator.sv
module spwm_modulator #(
   parameter int CLK_HZ        = 100_000_000,
   parameter int CARRIER_HZ    = 20_000,
   parameter int FOUT0_HZ      = 50,
   parameter int FOUT1_HZ      = 60,
   parameter int RAMP_MS       = 500,
   parameter int SAMPLE_W      = 12,
   parameter int MI_W          = 16,
   parameter int PHASE_FRAC    = 16,
   parameter int QUARTER_TABLE = 1
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            en_i,
   input  logic            freq_sel_i,
   input  logic [MI_W-1:0] mod_index_i,
   output logic            pwm_o,
   output logic            peak_o,
   output logic            zc_o
);
   localparam int     HALF      = CLK_HZ / (2 * CARRIER_HZ);
   localparam int     CW        = $clog2(HALF + 1);
   localparam longint PMOD      = 360 * (longint'(1) << PHASE_FRAC);
   localparam int     STEP0     = int'((PMOD * FOUT0_HZ + CARRIER_HZ / 2) / CARRIER_HZ);
   localparam int     STEP1     = int'((PMOD * FOUT1_HZ + CARRIER_HZ / 2) / CARRIER_HZ);
   localparam int     RAMP_RAW  = (CARRIER_HZ / 1000) * RAMP_MS;
   localparam int     RAMP_P    = (RAMP_RAW < 1) ? 1 : RAMP_RAW;
   localparam int     ENV_STEP  = (2 ** (MI_W - 1) + RAMP_P - 1) / RAMP_P;
   localparam int     DEPTH_W   = MI_W + 1;
   localparam int     PROD_W    = SAMPLE_W + DEPTH_W + 1;
   localparam int     LVL_W     = SAMPLE_W + 1;
   localparam int     TP_W      = LVL_W + CW;
   localparam logic [CW-1:0] MID = CW'(HALF / 2);
   localparam logic signed [PROD_W-1:0] OFFS = PROD_W'(2 ** (SAMPLE_W - 1));
   localparam logic signed [PROD_W-1:0] SPAN = PROD_W'(2 ** SAMPLE_W);

   if (HALF < 2) begin : g_bad_half
      $error("carrier half-period must be at least two clocks");
   end
   if (SAMPLE_W < 4 || SAMPLE_W > 16) begin : g_bad_sample
      $error("SAMPLE_W must lie in 4..16");
   end
   if (MI_W < 2 || MI_W > 16) begin : g_bad_mi
      $error("MI_W must lie in 2..16");
   end
   if (PHASE_FRAC < 1 || PHASE_FRAC > 20) begin : g_bad_frac
      $error("PHASE_FRAC must lie in 1..20");
   end
   if (QUARTER_TABLE != 0 && QUARTER_TABLE != 1) begin : g_bad_table
      $error("QUARTER_TABLE must be 0 or 1");
   end
   if (FOUT0_HZ >= CARRIER_HZ || FOUT1_HZ >= CARRIER_HZ) begin : g_bad_fout
      $error("output frequencies must be below the carrier");
   end

   logic [CW-1:0]              carrier_cnt;
   logic                       at_top;
   logic signed [SAMPLE_W-1:0] sample;
   logic                       wrap;
   logic [MI_W-1:0]            env_val;
   logic [CW-1:0]              thr_q;

   spwm_carrier #(.HALF(HALF), .CW(CW)) u_carrier (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
      .cnt_o(carrier_cnt), .top_o(at_top)
   );

   spwm_phase #(
      .FRAC(PHASE_FRAC), .SAMPLE_W(SAMPLE_W),
      .STEP0(STEP0), .STEP1(STEP1), .QUARTER(QUARTER_TABLE)
   ) u_phase (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .adv_i(at_top),
      .sel_i(freq_sel_i), .sample_o(sample), .wrap_o(wrap)
   );

   spwm_envelope #(.W(MI_W), .STEP(ENV_STEP)) u_env (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .adv_i(at_top),
      .env_o(env_val)
   );

   logic [2*MI_W-1:0]         depth_prod;
   logic [DEPTH_W-1:0]        depth;
   logic signed [PROD_W-1:0]  scaled;
   logic signed [PROD_W-1:0]  shifted;
   logic signed [PROD_W-1:0]  level;
   logic [LVL_W-1:0]          lvl_u;
   logic [TP_W-1:0]           thr_prod;
   logic [CW-1:0]             thr_next;

   always_comb begin
      depth_prod = {{MI_W{1'b0}}, mod_index_i} * {{MI_W{1'b0}}, env_val};
      depth      = depth_prod[2*MI_W-1:MI_W-1];
      scaled     = $signed({{(PROD_W - SAMPLE_W){sample[SAMPLE_W-1]}}, sample})
                 * $signed({{(PROD_W - DEPTH_W){1'b0}}, depth});
      shifted    = scaled >>> (MI_W - 1);
      level      = shifted + OFFS;
      if (level < 0) begin
         lvl_u = '0;
      end else if (level > SPAN) begin
         lvl_u = LVL_W'(2 ** SAMPLE_W);
      end else begin
         lvl_u = level[LVL_W-1:0];
      end
      thr_prod = {{CW{1'b0}}, lvl_u} * TP_W'(HALF);
      thr_next = thr_prod[SAMPLE_W +: CW];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i) begin
         thr_q  <= MID;
         pwm_o  <= 1'b0;
         peak_o <= 1'b0;
         zc_o   <= 1'b0;
      end else begin
         pwm_o  <= (carrier_cnt < thr_q);
         peak_o <= at_top;
         zc_o   <= wrap;
         if (at_top) begin
            thr_q <= thr_next;
         end
      end
   end

endmodule

// File: rtl/spwm_modulator_chk.sv
module spwm_modulator_chk #(
   parameter int HALF = 2500,
   parameter int CW   = 12,
   parameter int MI_W = 16
) (
   input logic            clk_i,
   input logic            rst_i,
   input logic            en_i,
   input logic            pwm_o,
   input logic            peak_o,
   input logic            zc_o,
   input logic [CW-1:0]   cnt,
   input logic [CW-1:0]   thr,
   input logic [MI_W-1:0] env
);

   // R10: reset forces every output low on the following cycle
   assert_reset_idle_R10: assert property (@(posedge clk_i)
      rst_i |=> (!pwm_o && !peak_o && !zc_o));

   // R9: a low enable forces every output low on the following cycle
   assert_disabled_low_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> (!pwm_o && !peak_o && !zc_o));

   // R2: the carrier never leaves its range
   assert_carrier_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt <= CW'(HALF));

   // R2: the peak strobe lasts a single clock
   assert_peak_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      peak_o |=> !peak_o);

   // R3: the threshold only moves together with a carrier-top strobe
   assert_ref_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && $past(en_i) && !$past(rst_i) && !peak_o) |-> $stable(thr));

   // R6: a cycle-start strobe never appears away from a carrier top
   assert_zc_on_peak_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      zc_o |-> peak_o);

   // R8: the envelope never falls while running and never exceeds unity
   assert_env_rise_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && $past(en_i) && !$past(rst_i)) |-> (env >= $past(env)));

   assert_env_cap_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      env <= MI_W'(2 ** (MI_W - 1)));

endmodule

bind spwm_modulator spwm_modulator_chk #(.HALF(HALF), .CW(CW), .MI_W(MI_W)) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
   .pwm_o(pwm_o), .peak_o(peak_o), .zc_o(zc_o),
   .cnt(carrier_cnt), .thr(thr_q), .env(env_val)
);

// File: tb/spwm_modulator_bench.sv
module spwm_modulator_bench;

   localparam int CLK_PERIOD = 10;
   localparam int T_CLK_HZ   = 400_000;
   localparam int T_CARRIER  = 20_000;
   localparam int T_RAMP_MS  = 5;
   localparam int H          = T_CLK_HZ / (2 * T_CARRIER);
   localparam longint PMOD   = 360 * 65536;
   localparam longint STEP_A = (PMOD * 50 + T_CARRIER / 2) / T_CARRIER;
   localparam longint STEP_B = (PMOD * 60 + T_CARRIER / 2) / T_CARRIER;
   localparam int RAMP_P     = T_CARRIER * T_RAMP_MS / 1000;
   localparam longint ESTEP  = (32768 + RAMP_P - 1) / RAMP_P;
   localparam int WATCHDOG   = 150_000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic        sel = 1'b0;
   logic [15:0] mi  = '0;
   logic        pwm;
   logic        pk;
   logic        zc;

   always #(CLK_PERIOD / 2) clk = ~clk;

   spwm_modulator #(
      .CLK_HZ(T_CLK_HZ), .CARRIER_HZ(T_CARRIER), .FOUT0_HZ(50), .FOUT1_HZ(60),
      .RAMP_MS(T_RAMP_MS)
   ) u_spwm_modulator (
      .clk_i(clk), .rst_i(rst), .en_i(en), .freq_sel_i(sel),
      .mod_index_i(mi), .pwm_o(pwm), .peak_o(pk), .zc_o(zc)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc   = 0;
   int    n_zc  = 0;
   string cur_req = "R10";

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)",
                  req, what, act, exp, cyc);
      end
   endtask

   function automatic longint sine_ref(input longint k);
      longint m;
      longint p;
      longint v;
      m = k % 180;
      p = m * (180 - m);
      v = (2047 * 4 * p) / (40500 - p);
      return (k >= 180) ? -v : v;
   endfunction

   // Behavioural reference: time within the carrier period, phase, envelope.
   int     t_pos = 0;
   longint ph    = 0;
   longint env   = 0;
   longint thr   = H / 2;
   bit     e_pwm = 0;
   bit     e_pk  = 0;
   bit     e_zc  = 0;

   always @(posedge clk) begin
      if (rst || !en) begin
         t_pos = 0; ph = 0; env = 0; thr = H / 2;
         e_pwm = 0; e_pk = 0; e_zc = 0;
      end else begin
         longint car;
         car   = (t_pos <= H) ? t_pos : 2 * H - t_pos;
         e_pwm = (car < thr);
         e_pk  = (t_pos == H);
         e_zc  = 0;
         if (t_pos == H) begin
            longint s;
            longint depth;
            longint sc;
            longint lvl;
            s     = sine_ref(ph / 65536);
            depth = (longint'(mi) * env) >> 15;
            sc    = (s * depth) >>> 15;
            lvl   = sc + 2048;
            if (lvl < 0) lvl = 0;
            if (lvl > 4096) lvl = 4096;
            thr   = (lvl * H) >> 12;
            ph    = ph + (sel ? STEP_B : STEP_A);
            if (ph >= PMOD) begin
               ph   = ph - PMOD;
               e_zc = 1;
            end
            env = env + ESTEP;
            if (env > 32768) env = 32768;
         end
         t_pos = (t_pos + 1) % (2 * H);
      end
   end

   int since   = 0;
   bit gap_ok  = 0;
   int rises   = 0;
   bit per_ok  = 0;
   bit prev_pw = 0;

   always @(negedge clk) begin
      cyc++;
      if (cyc >= WATCHDOG) begin
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
      check(cur_req, "pwm_o", longint'(pwm), longint'(e_pwm));
      check(cur_req, "peak_o", longint'(pk), longint'(e_pk));
      check(cur_req, "zc_o", longint'(zc), longint'(e_zc));
      if (!rst) begin
         check("R1", "pwm_o defined", longint'($isunknown(pwm)), 0);
      end
      since++;
      if (pwm && !prev_pw) rises++;
      prev_pw = pwm;
      if (pk) begin
         if (gap_ok) check("R2", "clocks between peak strobes", since, 2 * H);
         if (per_ok) check("R3", "pwm rising edges over one period above 1", longint'(rises > 1), 0);
         gap_ok = 1; since = 0; per_ok = 1; rises = 0;
      end
      if (zc) begin
         n_zc++;
         check("R6", "zc_o together with peak_o", longint'(pk), 1);
      end
      if (rst || !en) begin
         gap_ok = 0; per_ok = 0;
      end
   end

   task automatic drive(input bit r, input bit e, input bit s, input logic [15:0] m);
      @(posedge clk);
      #(CLK_PERIOD / 4);
      rst = r; en = e; sel = s; mi = m;
   endtask

   initial begin
      cur_req = "R10";
      repeat (5) @(negedge clk);
      check("R10", "pwm_o under reset", longint'(pwm), 0);
      check("R10", "peak_o under reset", longint'(pk), 0);
      check("R10", "zc_o under reset", longint'(zc), 0);

      drive(0, 0, 0, 16'd32768);
      repeat (4) @(posedge clk);

      cur_req = "R8";
      drive(0, 1, 0, 16'd32768);
      repeat (2500) @(posedge clk);

      cur_req = "R4";
      repeat (8000) @(posedge clk);

      cur_req = "R5";
      drive(0, 1, 1, 16'd32768);
      repeat (7000) @(posedge clk);

      cur_req = "R7";
      drive(0, 1, 1, 16'd65535);
      repeat (3000) @(posedge clk);
      drive(0, 1, 0, 16'd8192);
      repeat (2000) @(posedge clk);

      cur_req = "R9";
      repeat (7) @(posedge clk);
      drive(0, 0, 0, 16'd8192);
      repeat (2) @(negedge clk);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         check("R9", "pwm_o while disabled", longint'(pwm), 0);
         check("R9", "peak_o while disabled", longint'(pk), 0);
      end
      drive(0, 1, 0, 16'd40000);
      repeat (3000) @(posedge clk);

      @(negedge clk);
      check("R6", "cycle-start strobes seen at least twice", longint'(n_zc >= 2), 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule